// File: doc/BRIEF.md
# Telemetry Word Reversal Preprocessor

This block turns a serial telemetry stream of 8-bit intensity samples into parallel words, ready for storage, with no per-word software step. Bits arrive most significant first, one per clock in which the bit enable is high, so the stream can run at any rate up to the core clock. A frame-start marker realigns the bit and word counters to the frame boundary.

Each assembled word is mirrored end for end, so bit 7 swaps with bit 0, bit 6 with bit 1, and so on. Bits 1, 3 and 5 of the mirrored word are then inverted. The word is presented with a one-cycle valid strobe. The strobe carries the word's index within its frame and the frame's index within its picture, plus flags that mark the first and last word of a frame and the first and last frame of a picture. The number of words in a frame and the number of frames in a picture are parameters. If a frame-start marker cuts a word short, the partial bits are dropped and a one-cycle error pulse is raised.

Top module: `tlm_word_flip`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, word_valid_o, sync_err_o, word_o, both index outputs and all four position flags are zero. A reset in the middle of a word drops that word, and the next word is tagged word 0 of frame 0.
- R2: A bit is taken from bit_i only in a cycle where bit_en_i is high. Bits arrive most significant first. Cycles with bit_en_i low have no effect on the assembled words, whatever value bit_i holds.
- R3: word_valid_o is high for exactly one cycle, the cycle after the clock edge that samples the eighth bit of a word. word_o holds the transformed word during that cycle.
- R4: Given an assembled word d, word_o[i] = d[7-i] for i in 0, 2, 4, 6 and 7, and word_o[i] = ~d[7-i] for i in 1, 3 and 5. This is the bit-mirrored word XOR 8'h2A.
- R5: word_idx_o counts 0 to WORDS_PER_FRAME-1 over consecutive words and then wraps to 0. first_word_o is high when the index is 0, and last_word_o is high when it is WORDS_PER_FRAME-1.
- R6: frame_idx_o advances by one after the last word of a frame and wraps from FRAMES_PER_PIC-1 to 0. first_frame_o and last_frame_o mark indices 0 and FRAMES_PER_PIC-1.
- R7: A frame_start_i pulse clears the bit position. If bit_en_i is high in the same cycle, that bit is bit 7 of word 0. If bit_en_i is low, the next enabled bit is bit 7 of word 0.
- R8: If frame_start_i arrives while a word is partly assembled, the partial bits are discarded and produce no word. sync_err_o is high for exactly the one cycle after that frame_start_i.
- R9: If frame_start_i arrives after at least one word of the current frame has been output, the next word is tagged word 0 of the next frame, with the same wrap as R6. If frame_start_i arrives at a word boundary, sync_err_o stays low.
- R10: With bit_en_i held high, one word comes out every 8 cycles with no stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | Qualifies bit_i in this cycle |
| bit_i | input | 1 | Serial data bit, most significant first |
| frame_start_i | input | 1 | Frame boundary marker |
| word_o | output | 8 | Transformed word |
| word_valid_o | output | 1 | One-cycle strobe for word_o and its tags |
| word_idx_o | output | $clog2(WORDS_PER_FRAME) | Word index in frame |
| frame_idx_o | output | $clog2(FRAMES_PER_PIC) | Frame index in picture |
| first_word_o | output | 1 | Word index is 0 |
| last_word_o | output | 1 | Word index is last |
| first_frame_o | output | 1 | Frame index is 0 |
| last_frame_o | output | 1 | Frame index is last |
| sync_err_o | output | 1 | Frame marker cut a word short |

## Verification
The hardest case to reach is a frame marker that lands in the middle of a word after earlier words of the same frame have already been output. In that case one marker must at the same time drop the partial bits, raise the error pulse and advance the frame index. The stimulus first streams several words to build up the frame state. It then sends three or four loose bits, followed by a marker. The marker comes once together with an enabled bit and once in a cycle with the enable low. The next word's tags show that the frame advanced, and the count of output words shows that nothing of the partial word came out.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  parameter int unsigned TLM_WORD_W = 8;
  typedef logic [TLM_WORD_W-1:0] tlm_word_t;
  // inversion applied to the mirrored word: bits 1, 3, 5
  localparam tlm_word_t TLM_INV_MASK = 8'h2A;

  function automatic tlm_word_t tlm_mirror(input tlm_word_t w);
    tlm_word_t r;
    for (int i = 0; i < TLM_WORD_W; i++) r[i] = w[TLM_WORD_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/tlm_deser.sv
module tlm_deser
  import tlm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bit_en_i,
  input  logic      bit_i,
  input  logic      frame_start_i,
  output logic      done_o,
  output tlm_word_t word_o,
  output logic      pending_o
);
  localparam int unsigned CW = $clog2(TLM_WORD_W);

  logic [CW-1:0]           cnt_q, eff_cnt;
  logic [TLM_WORD_W-2:0]   sh_q;

  // frame marker realigns before this cycle's bit is counted
  assign eff_cnt   = frame_start_i ? '0 : cnt_q;
  assign done_o    = bit_en_i && (eff_cnt == CW'(TLM_WORD_W-1));
  assign word_o    = {sh_q, bit_i};
  assign pending_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (bit_en_i) begin
      sh_q  <= {sh_q[TLM_WORD_W-3:0], bit_i};
      cnt_q <= done_o ? '0 : eff_cnt + CW'(1);
    end else if (frame_start_i) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/tlm_flip.sv
module tlm_flip
  import tlm_pkg::*;
#(
  parameter bit MASK_FIRST = 1'b0
) (
  input  tlm_word_t word_i,
  output tlm_word_t word_o
);
  tlm_word_t pre, mir;

  generate
    if (MASK_FIRST) begin : g_mask_first
      assign pre = word_i ^ tlm_mirror(TLM_INV_MASK);
    end else begin : g_mask_last
      assign pre = word_i;
    end

    for (genvar i = 0; i < TLM_WORD_W; i++) begin : g_mir
      assign mir[i] = pre[TLM_WORD_W-1-i];
    end

    if (MASK_FIRST) begin : g_out_plain
      assign word_o = mir;
    end else begin : g_out_mask
      assign word_o = mir ^ TLM_INV_MASK;
    end
  endgenerate
endmodule

// File: rtl/tlm_pos.sv
module tlm_pos #(
  parameter int unsigned WORDS  = 256,
  parameter int unsigned FRAMES = 256,
  localparam int unsigned IW = (WORDS  > 1) ? $clog2(WORDS)  : 1,
  localparam int unsigned FW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          done_i,
  output logic [IW-1:0] word_idx_o,
  output logic [FW-1:0] frame_idx_o
);
  logic [IW-1:0] word_q, eff_word;
  logic [FW-1:0] frame_q, eff_frame, next_frame;
  logic          adv;

  function automatic logic [FW-1:0] inc_frame(input logic [FW-1:0] f);
    return (f == FW'(FRAMES-1)) ? '0 : f + FW'(1);
  endfunction

  // a marker after words of this frame were issued opens the next frame
  assign adv        = frame_start_i && (word_q != '0);
  assign eff_word   = frame_start_i ? '0 : word_q;
  assign eff_frame  = adv ? inc_frame(frame_q) : frame_q;
  assign next_frame = inc_frame(eff_frame);

  assign word_idx_o  = eff_word;
  assign frame_idx_o = eff_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      frame_q <= '0;
    end else if (done_i) begin
      if (eff_word == IW'(WORDS-1)) begin
        word_q  <= '0;
        frame_q <= next_frame;
      end else begin
        word_q  <= eff_word + IW'(1);
        frame_q <= eff_frame;
      end
    end else begin
      word_q  <= eff_word;
      frame_q <= eff_frame;
    end
  end
endmodule

// File: rtl/tlm_word_flip.sv
module tlm_word_flip
  import tlm_pkg::*;
#(
  parameter int unsigned WORDS_PER_FRAME = 256,
  parameter int unsigned FRAMES_PER_PIC  = 256,
  parameter bit          MASK_FIRST      = 1'b0,
  localparam int unsigned IW = (WORDS_PER_FRAME > 1) ? $clog2(WORDS_PER_FRAME) : 1,
  localparam int unsigned FW = (FRAMES_PER_PIC  > 1) ? $clog2(FRAMES_PER_PIC)  : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bit_en_i,
  input  logic                  bit_i,
  input  logic                  frame_start_i,
  output logic [TLM_WORD_W-1:0] word_o,
  output logic                  word_valid_o,
  output logic [IW-1:0]         word_idx_o,
  output logic [FW-1:0]         frame_idx_o,
  output logic                  first_word_o,
  output logic                  last_word_o,
  output logic                  first_frame_o,
  output logic                  last_frame_o,
  output logic                  sync_err_o
);
  logic          done, pending;
  tlm_word_t     raw, flipped;
  logic [IW-1:0] cur_word;
  logic [FW-1:0] cur_frame;

  tlm_deser u_deser (
    .clk_i, .rst_ni, .bit_en_i, .bit_i, .frame_start_i,
    .done_o(done), .word_o(raw), .pending_o(pending)
  );

  tlm_flip #(.MASK_FIRST(MASK_FIRST)) u_flip (.word_i(raw), .word_o(flipped));

  tlm_pos #(.WORDS(WORDS_PER_FRAME), .FRAMES(FRAMES_PER_PIC)) u_pos (
    .clk_i, .rst_ni, .frame_start_i, .done_i(done),
    .word_idx_o(cur_word), .frame_idx_o(cur_frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o        <= '0;
      word_valid_o  <= 1'b0;
      word_idx_o    <= '0;
      frame_idx_o   <= '0;
      first_word_o  <= 1'b0;
      last_word_o   <= 1'b0;
      first_frame_o <= 1'b0;
      last_frame_o  <= 1'b0;
      sync_err_o    <= 1'b0;
    end else begin
      word_valid_o <= done;
      sync_err_o   <= frame_start_i && pending;
      if (done) begin
        word_o        <= flipped;
        word_idx_o    <= cur_word;
        frame_idx_o   <= cur_frame;
        first_word_o  <= (cur_word == '0);
        last_word_o   <= (cur_word == IW'(WORDS_PER_FRAME-1));
        first_frame_o <= (cur_frame == '0);
        last_frame_o  <= (cur_frame == FW'(FRAMES_PER_PIC-1));
      end
    end
  end
endmodule

// File: rtl/tlm_word_flip_chk.sv
module tlm_word_flip_chk #(
  parameter int unsigned WORDS_PER_FRAME = 256,
  parameter int unsigned FRAMES_PER_PIC  = 256,
  localparam int unsigned IW = (WORDS_PER_FRAME > 1) ? $clog2(WORDS_PER_FRAME) : 1,
  localparam int unsigned FW = (FRAMES_PER_PIC  > 1) ? $clog2(FRAMES_PER_PIC)  : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bit_en_i,
  input logic          frame_start_i,
  input logic          word_valid_o,
  input logic [IW-1:0] word_idx_o,
  input logic [FW-1:0] frame_idx_o,
  input logic          sync_err_o
);
  logic [IW-1:0] prev_idx_q;
  logic          seen_q, fs_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_idx_q <= '0;
      seen_q     <= 1'b0;
      fs_seen_q  <= 1'b0;
    end else begin
      if (word_valid_o) begin
        prev_idx_q <= word_idx_o;
        seen_q     <= 1'b1;
        fs_seen_q  <= 1'b0;
      end
      if (frame_start_i) fs_seen_q <= 1'b1;
    end
  end

  // R3: strobe is a single-cycle pulse
  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  // R2: a word only completes on an enabled bit
  p_valid_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(bit_en_i));

  // R5: consecutive words step the index with wrap
  p_word_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && seen_q && !fs_seen_q) |->
      word_idx_o == ((prev_idx_q == IW'(WORDS_PER_FRAME-1)) ? '0 : prev_idx_q + IW'(1)));

  // R6: frame index stays in range
  p_frame_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> frame_idx_o <= FW'(FRAMES_PER_PIC-1));

  // R8: error pulse follows a marker and carries no word
  p_err_after_fs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |-> ($past(frame_start_i) && !word_valid_o));

  // R9: first word after a marker is word 0
  p_fs_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && fs_seen_q) |-> word_idx_o == '0);
endmodule

bind tlm_word_flip tlm_word_flip_chk #(
  .WORDS_PER_FRAME(WORDS_PER_FRAME), .FRAMES_PER_PIC(FRAMES_PER_PIC)
) u_chk (
  .clk_i, .rst_ni, .bit_en_i, .frame_start_i, .word_valid_o,
  .word_idx_o, .frame_idx_o, .sync_err_o
);

// File: tb/tb_tlm_word_flip.sv
module tb_tlm_word_flip;
  localparam int TW = 4;
  localparam int TF = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0, bit_i = 1'b0, frame_start_i = 1'b0;
  logic [7:0] word_o;
  logic       word_valid_o, first_word_o, last_word_o, first_frame_o, last_frame_o, sync_err_o;
  logic [1:0] word_idx_o, frame_idx_o;

  tlm_word_flip #(.WORDS_PER_FRAME(TW), .FRAMES_PER_PIC(TF)) dut (.*);

  always #5 clk_i = ~clk_i;

  int cyc = 0, n_chk = 0, n_err = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int         cap_n = 0, sent = 0, err_hi = 0, err_cyc = -1;
  logic [7:0] cap_w[64];
  int         cap_i[64], cap_f[64], cap_c[64], exp_c[64];
  logic [3:0] cap_fl[64];
  int         last_cyc, fs_cyc;

  always @(negedge clk_i) begin
    if (rst_ni && word_valid_o) begin
      cap_w[cap_n]  = word_o;
      cap_i[cap_n]  = word_idx_o;
      cap_f[cap_n]  = frame_idx_o;
      cap_c[cap_n]  = cyc;
      cap_fl[cap_n] = {first_word_o, last_word_o, first_frame_o, last_frame_o};
      cap_n++;
    end
    if (rst_ni && sync_err_o) begin
      err_hi++;
      err_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic fs, input bit gap);
    @(negedge clk_i);
    bit_en_i = 1'b1; bit_i = b; frame_start_i = fs;
    last_cyc = cyc;
    if (gap) begin
      @(negedge clk_i);
      bit_en_i = 1'b0; bit_i = ~b; frame_start_i = 1'b0;
    end
  endtask

  task automatic send_word(input logic [7:0] w, input logic fs, input bit gap);
    for (int i = 7; i >= 0; i--) send_bit(w[i], fs && (i == 7), gap);
    exp_c[sent] = last_cyc + 1;
    sent++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      bit_en_i = 1'b0; frame_start_i = 1'b0; bit_i = 1'b0;
    end
  endtask

  task automatic chk_cap(input int k, input logic [7:0] w, input int idx, input int frm, input string req);
    logic [3:0] fl;
    fl = {idx == 0, idx == TW-1, frm == 0, frm == TF-1};
    chk(k < cap_n, req, "word missing", cap_n, k + 1);
    chk(cap_w[k] == w, req, "word", cap_w[k], w);
    chk(cap_i[k] == idx, "R5", "word index", cap_i[k], idx);
    chk(cap_f[k] == frm, "R6", "frame index", cap_f[k], frm);
    chk(cap_fl[k] == fl, "R5 R6", "flags", cap_fl[k], fl);
    chk(cap_c[k] == exp_c[k], "R3", "strobe cycle", cap_c[k], exp_c[k]);
  endtask

  // input word, expected output (mirror then XOR 8'h2A)
  localparam logic [15:0] VEC[12] = '{
    16'h002A, 16'hFFD5, 16'h01AA, 16'h802B, 16'hA58F, 16'h0FDA,
    16'h3C16, 16'h1262, 16'h5580, 16'hAA7F, 16'hC3E9, 16'h7E54};

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int v0, e0;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk({word_valid_o, sync_err_o, word_o, word_idx_o, frame_idx_o, first_word_o,
         last_word_o, first_frame_o, last_frame_o} == '0, "R1", "reset outputs", word_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!word_valid_o && word_o == 8'h00, "R1", "after release", word_o, 0);

    // R2 R4 R5 R6: table of words, gaps with noise on odd entries
    for (int k = 0; k < 12; k++) send_word(VEC[k][15:8], k == 0, k[0]);
    idle(2);
    for (int k = 0; k < 12; k++) chk_cap(k, VEC[k][7:0], k % TW, (k / TW) % TF, "R4");

    // R10: back to back, frame wraps to 0
    send_word(8'h01, 1'b0, 1'b0);
    send_word(8'h80, 1'b0, 1'b0);
    idle(2);
    chk_cap(12, 8'hAA, 0, 0, "R10");
    chk_cap(13, 8'h2B, 1, 0, "R10");
    chk(cap_c[13] - cap_c[12] == 8, "R10", "word spacing", cap_c[13] - cap_c[12], 8);

    // R8: marker with enabled bit cuts a partial word
    v0 = cap_n; e0 = err_hi;
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0, 1'b0);
    send_word(8'h00, 1'b1, 1'b0);
    fs_cyc = exp_c[sent-1] - 8;
    idle(2);
    chk(cap_n - v0 == 1, "R8", "words after cut", cap_n - v0, 1);
    chk(err_hi - e0 == 1, "R8", "error pulse width", err_hi - e0, 1);
    chk(err_cyc == fs_cyc + 1, "R8", "error cycle", err_cyc, fs_cyc + 1);
    chk_cap(14, 8'h2A, 0, 1, "R8");

    // R9: marker at a word boundary, frame advances, no error
    e0 = err_hi;
    send_word(8'hFF, 1'b1, 1'b0);
    idle(2);
    chk(err_hi == e0, "R9", "no error at boundary", err_hi - e0, 0);
    chk_cap(15, 8'hD5, 0, 2, "R9");

    // R7: marker with enable low mid-word, frame wraps
    e0 = err_hi;
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    bit_en_i = 1'b0; frame_start_i = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    send_word(8'h0F, 1'b0, 1'b0);
    idle(2);
    chk(err_hi - e0 == 1, "R7", "error on idle marker", err_hi - e0, 1);
    chk_cap(16, 8'hDA, 0, 0, "R7");

    // R1: reset mid-word
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, 1'b0);
    @(negedge clk_i);
    bit_en_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk_i);
    chk(word_o == 8'h00 && !word_valid_o && word_idx_o == 0 && frame_idx_o == 0,
        "R1", "async clear", word_o, 0);
    rst_ni = 1'b1;
    send_word(8'h3C, 1'b0, 1'b0);
    idle(2);
    chk_cap(17, 8'h16, 0, 0, "R1");
    chk(cap_n == 18, "R1", "word count", cap_n, 18);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule